// File: doc/BRIEF.md
# Low-Transition Don't-Care Filler

This block takes one partly specified test vector of `N` bits and turns it into a fully specified vector with as few adjacent-bit value changes as possible. The vector arrives as two words: a value word, and a care mask in which a 1 marks a specified bit. Every unspecified bit is given a defined value taken from the specified bits around it. Specified bits are never altered. Fewer value changes between neighbouring positions means less switching while the vector is applied, and so lower test power.

The filled vector leaves through a single registered stage, together with the number of adjacent-bit changes it contains. Both the input side and the output side use a valid/ready handshake. The position written leftmost in a vector corresponds to word bit `N-1`.

Top module: `lowtog_fill`

## Requirements
- R1: Every bit whose care-mask bit is 1 appears in the output with the same value it had in the value word.
- R2: An unspecified bit that has a specified bit somewhere to its left (a higher word index) takes the value of the nearest such bit. This covers three cases: a gap whose two ends agree takes that value, a gap whose ends differ copies its left end, and trailing bits copy the last specified bit.
- R3: Unspecified bits to the left of the leftmost specified bit copy the value of that leftmost specified bit.
- R4: A vector with an all-zero care mask is filled with all zeros.
- R5: The number of adjacent-bit changes in the filled vector equals the minimum over all possible assignments of the unspecified bits.
- R6: `out_count` (width ceil(log2 N)+1) equals the number of positions i where filled bits i and i+1 differ.
- R7: The leftmost written bit maps to word bit N-1. For N=5, the vector 1X10X (value 5'b10100, care 5'b10110) is filled to 5'b11100 with a count of 1.
- R8: A transfer happens on a rising edge when valid and ready are both high. `in_ready` is high whenever the output register is empty or is being read in the same cycle. An accepted vector shows `out_valid` high after that edge.
- R9: While `out_valid` is high and `out_ready` is low, `out_vec` and `out_count` hold their values and `out_valid` stays high.
- R10: A synchronous active-high `rst` clears `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input vector is present |
| in_ready | output | 1 | Block can take a vector this cycle |
| in_value | input | N | Bit values, bit N-1 leftmost |
| in_care | input | N | 1 = bit is specified |
| out_valid | output | 1 | Filled vector is present |
| out_ready | input | 1 | Consumer takes the vector this cycle |
| out_vec | output | N | Filled vector |
| out_count | output | ceil(log2 N)+1 | Adjacent-bit changes in `out_vec` |

## Verification
For a 5-bit configuration, the bench applies every one of the 243 vectors in which each position is 0, 1 or unspecified. This covers no defined bits, all bits defined, leading, trailing and interior gaps, and gaps whose ends agree or differ. Each result is compared with the fill rule computed in the bench, which separates left-copy from right-copy and tells the leading-gap case apart from the empty-mask case. Each result is also compared with a brute-force search over every fill, which catches a fill that follows the rule but adds changes. Separate patterns hold `out_ready` low while new input waits, check the readiness path in the same cycle, and apply reset while a result is still pending.

// File: rtl/lowtog_pkg.sv
`timescale 1ns/1ps
package lowtog_pkg;
   // width of a count that can reach n-1 with margin
   function automatic int count_width(input int n);
      return $clog2(n) + 1;
   endfunction
endpackage

// File: rtl/lowtog_scan.sv
`timescale 1ns/1ps
module lowtog_scan #(
   parameter int N = 16
) (
   input  logic [N-1:0] val,
   input  logic [N-1:0] care,
   output logic [N-1:0] fill
);
   logic [N-1:0] seen_l, from_l;   // nearest defined at or above index
   logic [N-1:0] seen_r, from_r;   // nearest defined at or below index

   always_comb begin
      seen_l = '0;
      from_l = '0;
      for (int i = N-1; i >= 0; i--) begin
         if (i == N-1) begin
            seen_l[i] = care[i];
            from_l[i] = care[i] & val[i];
         end else begin
            seen_l[i] = care[i] | seen_l[i+1];
            from_l[i] = care[i] ? val[i] : from_l[i+1];
         end
      end
   end

   always_comb begin
      seen_r = '0;
      from_r = '0;
      for (int i = 0; i < N; i++) begin
         if (i == 0) begin
            seen_r[i] = care[i];
            from_r[i] = care[i] & val[i];
         end else begin
            seen_r[i] = care[i] | seen_r[i-1];
            from_r[i] = care[i] ? val[i] : from_r[i-1];
         end
      end
   end

   always_comb begin
      for (int i = 0; i < N; i++)
         fill[i] = seen_l[i] ? from_l[i] : (seen_r[i] & from_r[i]);
   end
endmodule

// File: rtl/lowtog_count.sv
`timescale 1ns/1ps
module lowtog_count #(
   parameter int N  = 16,
   parameter int CW = 5
) (
   input  logic [N-1:0]  vec,
   output logic [CW-1:0] cnt
);
   logic [N-2:0] edge_w;
   assign edge_w = vec[N-1:1] ^ vec[N-2:0];

   always_comb begin
      cnt = '0;
      for (int i = 0; i < N-1; i++)
         cnt = cnt + CW'(edge_w[i]);
   end
endmodule

// File: rtl/lowtog_stage.sv
`timescale 1ns/1ps
module lowtog_stage #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [W-1:0] in_data,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [W-1:0] out_data
);
   assign in_ready = !out_valid || out_ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
      end else if (in_ready) begin
         out_valid <= in_valid;
      end
   end

   always_ff @(posedge clk) begin
      if (in_valid && in_ready)
         out_data <= in_data;
   end

   a_r8_accept: assert property (@(posedge clk) disable iff (rst)
      in_valid && in_ready |=> out_valid);

   a_r9_hold: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |=> out_valid && $stable(out_data));

   a_r10_reset_clears: assert property (@(posedge clk)
      $past(rst) |-> !out_valid);
endmodule

// File: rtl/lowtog_fill.sv
`timescale 1ns/1ps
module lowtog_fill
   import lowtog_pkg::*;
#(
   parameter int N  = 16,
   parameter int CW = count_width(N)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          in_valid,
   output logic          in_ready,
   input  logic [N-1:0]  in_value,
   input  logic [N-1:0]  in_care,
   output logic          out_valid,
   input  logic          out_ready,
   output logic [N-1:0]  out_vec,
   output logic [CW-1:0] out_count
);
   localparam int W = N + CW;

   generate
      if (N < 2) begin : g_bad_width
         $error("lowtog_fill: N must be at least 2");
      end
      if (CW < $clog2(N) + 1) begin : g_bad_count
         $error("lowtog_fill: CW too narrow for N");
      end
   endgenerate

   logic [N-1:0]  fill_w;
   logic [CW-1:0] cnt_w;
   logic [W-1:0]  held;

   lowtog_scan #(.N(N)) u_scan (
      .val  (in_value),
      .care (in_care),
      .fill (fill_w)
   );

   lowtog_count #(.N(N), .CW(CW)) u_count (
      .vec (fill_w),
      .cnt (cnt_w)
   );

   lowtog_stage #(.W(W)) u_stage (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_data   ({fill_w, cnt_w}),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_data  (held)
   );

   assign out_vec   = held[W-1:CW];
   assign out_count = held[CW-1:0];

   a_r1_care_pass: assert property (@(posedge clk) disable iff (rst)
      in_valid |-> ((fill_w ^ in_value) & in_care) == '0);

   a_r4_empty_mask: assert property (@(posedge clk) disable iff (rst)
      in_valid && in_care == '0 |-> fill_w == '0);

   a_r6_zero_iff_flat: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> ((out_count == '0) == (out_vec == '0 || out_vec == '1)));

   a_r6_bound: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> out_count <= CW'(N-1));
endmodule

// File: tb/lowtog_fill_bench.sv
`timescale 1ns/1ps
module lowtog_fill_bench;
   localparam int N  = 5;
   localparam int CW = $clog2(N) + 1;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [N-1:0]  in_value = '0;
   logic [N-1:0]  in_care = '0;
   logic          out_valid;
   logic          out_ready = 1'b1;
   logic [N-1:0]  out_vec;
   logic [CW-1:0] out_count;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   lowtog_fill #(.N(N)) u_lowtog_fill (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_value(in_value), .in_care(in_care), .out_valid(out_valid),
      .out_ready(out_ready), .out_vec(out_vec), .out_count(out_count)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int trans(input logic [N-1:0] v);
      int t = 0;
      for (int i = 0; i < N-1; i++) t += int'(v[i] ^ v[i+1]);
      return t;
   endfunction

   // fill rule from R2, R3, R4
   function automatic logic [N-1:0] rule_fill(input logic [N-1:0] v, input logic [N-1:0] c);
      logic [N-1:0] r = '0;
      int first = -1;
      logic cur = 1'b0;
      for (int i = N-1; i >= 0; i--) begin
         if (c[i]) begin
            cur = v[i];
            r[i] = v[i];
            if (first < 0) first = i;
         end else if (first >= 0) begin
            r[i] = cur;
         end
      end
      if (first >= 0)
         for (int i = N-1; i > first; i--) r[i] = v[first];
      return r;
   endfunction

   function automatic int brute_min(input logic [N-1:0] v, input logic [N-1:0] c);
      int best = N;
      for (int f = 0; f < (1 << N); f++) begin
         logic [N-1:0] cand = N'(f);
         if (((cand ^ v) & c) == '0 && trans(cand) < best) best = trans(cand);
      end
      return best;
   endfunction

   initial begin
      #(200000 * 10);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [N-1:0] exp_v;
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R10 reset state", int'(out_valid), 0);
      rst = 1'b0;

      // exhaustive sweep: digit 0 -> defined 0, 1 -> defined 1, 2 -> unspecified
      for (int code = 0; code < 243; code++) begin
         int rem = code;
         logic [N-1:0] v = '0;
         logic [N-1:0] c = '0;
         for (int i = 0; i < N; i++) begin
            int d = rem % 3;
            rem = rem / 3;
            c[i] = (d != 2);
            v[i] = (d == 1);
         end
         @(negedge clk);
         chk(in_ready == 1'b1, "R8 ready when empty", int'(in_ready), 1);
         in_value = v; in_care = c; in_valid = 1'b1;
         @(negedge clk);
         in_valid = 1'b0;
         exp_v = rule_fill(v, c);
         chk(out_valid == 1'b1, "R8 one-stage latency", int'(out_valid), 1);
         chk(((out_vec ^ v) & c) == '0, "R1 care bits kept", int'(out_vec), int'(v));
         chk(out_vec == exp_v, (c == '0) ? "R4 empty mask" : "R2 R3 fill rule",
             int'(out_vec), int'(exp_v));
         chk(trans(out_vec) == brute_min(v, c), "R5 minimal changes",
             trans(out_vec), brute_min(v, c));
         chk(int'(out_count) == trans(out_vec), "R6 count", int'(out_count), trans(out_vec));
      end

      // R7 worked example 1X10X
      @(negedge clk);
      in_value = 5'b10100; in_care = 5'b10110; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk(out_vec == 5'b11100, "R7 1X10X fill", int'(out_vec), 28);
      chk(int'(out_count) == 1, "R7 1X10X count", int'(out_count), 1);

      // back-pressure
      @(negedge clk);
      out_ready = 1'b0;
      in_value = 5'b10100; in_care = 5'b10110; in_valid = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b1, "R8 accepted", int'(out_valid), 1);
      chk(in_ready == 1'b0, "R8 not ready when full", int'(in_ready), 0);
      in_value = 5'b00000; in_care = 5'b00000;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk(out_valid == 1'b1 && out_vec == 5'b11100, "R9 hold vector", int'(out_vec), 28);
         chk(int'(out_count) == 1, "R9 hold count", int'(out_count), 1);
      end
      out_ready = 1'b1;
      #1;
      chk(in_ready == 1'b1, "R8 ready while read", int'(in_ready), 1);
      @(negedge clk);
      in_valid = 1'b0;
      chk(out_valid == 1'b1 && out_vec == 5'b00000, "R8 pass-through", int'(out_vec), 0);
      @(negedge clk);
      chk(out_valid == 1'b0, "R8 drained", int'(out_valid), 0);

      // reset with pending result
      out_ready = 1'b0;
      in_value = 5'b11111; in_care = 5'b11111; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk(out_valid == 1'b1, "R8 pending before reset", int'(out_valid), 1);
      rst = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0, "R10 reset clears", int'(out_valid), 0);
      rst = 1'b0;
      out_ready = 1'b1;
      @(negedge clk);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule